// File: doc/BRIEF.md
# Vector Mode Propagation Unit

This unit decides the vector mode of an instruction's destination register. Each source register carries a 4-bit mode nibble. The instruction decoder also supplies a few flags. From these the unit forms the destination nibble and decides whether the instruction must trap as illegal. A neighbouring block reads the nibbles out of the per-register mode state and writes the result back. This unit holds no state and has no clock.

The unit sits in a decode stream as a pass-through stage with a valid/ready handshake. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so back-pressure from downstream reaches the producer in the same cycle. A transfer happens in a cycle where both valid and ready are high. The destination write enable pulses only on a transfer that is not illegal.

Mode nibble layout:
- Bits 1:0 give the sub-vector length minus one.
- Bits 3:2 give the kind: 00 is scalar, 01 is an unpredicated vector, and 10 or 11 is a predicated vector.

Top module: `vmp_unit`

## Requirements
- R1: Bits 1:0 of every nibble encode the sub-vector length minus one, so 00 means 1 and 11 means 4. The result length field uses the same code.
- R2: Bits 3:2 encode the kind. 00 is scalar, 01 is an unpredicated vector, and 10 or 11 is a predicated vector.
- R3: When `expl_en` is high, `res_mode` equals `expl_mode`, the sources have no effect, and `illegal` stays low.
- R4: Suppose `expl_en` and `mixed_ok` are low and two used sources have different length fields. Then `illegal` equals `in_valid`.
- R5: When `mixed_ok` is high, differing lengths never raise `illegal`. The result length is then taken from the lowest-indexed used source.
- R6: When `len_ovr_en` is high and `expl_en` is low, the result length field equals `len_ovr`.
- R7: Without an override, the result is scalar (00) when every used source is scalar and a vector otherwise. When `kind_ovr_en` is high, `kind_ovr_vec` decides scalar (0) or vector (1).
- R8: A vector result copies its kind bits from the lowest-indexed used source that is a vector. If no used source is a vector, the kind is 01.
- R9: Sources with their `src_used` bit low take no part in the result or the length check. With no used source and no override, the result is 0000.
- R10: `illegal` forces `dst_we` low.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. `dst_we` is high only when `in_valid` and `out_ready` are both high and `illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Unit can accept the instruction |
| src_mode | input | 4*NSRC | Source mode nibbles, source i at bits 4i+3:4i |
| src_used | input | NSRC | Per-source flag: operand is read by the instruction |
| expl_en | input | 1 | Instruction encodes its mode explicitly |
| expl_mode | input | 4 | Explicit destination mode |
| mixed_ok | input | 1 | Instruction accepts differing source lengths |
| len_ovr_en | input | 1 | Result length override enable |
| len_ovr | input | 2 | Override length code |
| kind_ovr_en | input | 1 | Scalar/vector override enable |
| kind_ovr_vec | input | 1 | Override value: 1 vector, 0 scalar |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| res_mode | output | 4 | Destination mode nibble |
| illegal | output | 1 | Illegal-instruction trap request |
| dst_we | output | 1 | Write the destination mode nibble |

## Verification
The unit holds no state, so any fault in the source scan or the result selection shows on `res_mode`, `illegal` or `dst_we` in the same cycle as the stimulus. If the scan picks the wrong source, the error shows as a predication kind or length copied from the wrong operand. Directed cases therefore place the deciding source at different indices. A length check that ignores the used flags, or that is not suppressed by `mixed_ok` or `expl_en`, raises a false trap and drops the write enable. An inverted handshake path shows as `in_ready` or `dst_we` disagreeing with `out_ready`.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  localparam int LEN_W  = 2;
  localparam int KIND_W = 2;
  localparam int MODE_W = LEN_W + KIND_W;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [LEN_W-1:0]  len;
  } mode_t;

  localparam logic [KIND_W-1:0] KIND_SCALAR = 2'b00;
  localparam logic [KIND_W-1:0] KIND_VEC    = 2'b01;
endpackage

// File: rtl/vmp_src_scan.sv
module vmp_src_scan
  import vmp_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC*MODE_W-1:0] src_mode,
  input  logic [NSRC-1:0]        src_used,
  output logic                   any_used,
  output logic                   any_vec,
  output logic                   len_mismatch,
  output logic [LEN_W-1:0]       first_len,
  output logic [KIND_W-1:0]      first_vec_kind
);
  mode_t            m      [NSRC];
  logic [NSRC-1:0]  is_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign m[g]      = mode_t'(src_mode[g*MODE_W +: MODE_W]);
    assign is_vec[g] = src_used[g] && (m[g].kind != KIND_SCALAR);
  end

  assign any_used = |src_used;
  assign any_vec  = |is_vec;

  always_comb begin
    logic seen;
    logic vseen;
    seen           = 1'b0;
    vseen          = 1'b0;
    first_len      = '0;
    first_vec_kind = KIND_VEC;
    len_mismatch   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_used[i]) begin
        if (!seen) begin
          seen      = 1'b1;
          first_len = m[i].len;
        end else if (m[i].len != first_len) begin
          len_mismatch = 1'b1;
        end
      end
      if (is_vec[i] && !vseen) begin
        vseen          = 1'b1;
        first_vec_kind = m[i].kind;
      end
    end
  end
endmodule

// File: rtl/vmp_result_sel.sv
module vmp_result_sel
  import vmp_pkg::*;
(
  input  logic              expl_en,
  input  logic [MODE_W-1:0] expl_mode,
  input  logic              mixed_ok,
  input  logic              len_ovr_en,
  input  logic [LEN_W-1:0]  len_ovr,
  input  logic              kind_ovr_en,
  input  logic              kind_ovr_vec,
  input  logic              any_vec,
  input  logic              len_mismatch,
  input  logic [LEN_W-1:0]  first_len,
  input  logic [KIND_W-1:0] first_vec_kind,
  output logic [MODE_W-1:0] res_mode,
  output logic              trap
);
  logic  vec_res;
  mode_t derived;

  assign vec_res = kind_ovr_en ? kind_ovr_vec : any_vec;

  always_comb begin
    derived.len  = len_ovr_en ? len_ovr : first_len;
    derived.kind = KIND_SCALAR;
    if (vec_res) derived.kind = any_vec ? first_vec_kind : KIND_VEC;
  end

  assign res_mode = expl_en ? expl_mode : MODE_W'(derived);
  assign trap     = !expl_en && !mixed_ok && len_mismatch;
endmodule

// File: rtl/vmp_unit.sv
module vmp_unit
  import vmp_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NSRC*MODE_W-1:0] src_mode,
  input  logic [NSRC-1:0]        src_used,
  input  logic                   expl_en,
  input  logic [MODE_W-1:0]      expl_mode,
  input  logic                   mixed_ok,
  input  logic                   len_ovr_en,
  input  logic [LEN_W-1:0]       len_ovr,
  input  logic                   kind_ovr_en,
  input  logic                   kind_ovr_vec,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [MODE_W-1:0]      res_mode,
  output logic                   illegal,
  output logic                   dst_we
);
  logic              any_used;
  logic              any_vec;
  logic              len_mismatch;
  logic [LEN_W-1:0]  first_len;
  logic [KIND_W-1:0] first_vec_kind;
  logic              trap;

  vmp_src_scan #(.NSRC(NSRC)) scan_i (
    .src_mode       (src_mode),
    .src_used       (src_used),
    .any_used       (any_used),
    .any_vec        (any_vec),
    .len_mismatch   (len_mismatch),
    .first_len      (first_len),
    .first_vec_kind (first_vec_kind)
  );

  vmp_result_sel sel_i (
    .expl_en        (expl_en),
    .expl_mode      (expl_mode),
    .mixed_ok       (mixed_ok),
    .len_ovr_en     (len_ovr_en),
    .len_ovr        (len_ovr),
    .kind_ovr_en    (kind_ovr_en),
    .kind_ovr_vec   (kind_ovr_vec),
    .any_vec        (any_vec),
    .len_mismatch   (len_mismatch),
    .first_len      (first_len),
    .first_vec_kind (first_vec_kind),
    .res_mode       (res_mode),
    .trap           (trap)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign illegal   = in_valid && trap;
  assign dst_we    = in_valid && out_ready && !trap;
endmodule

// File: rtl/vmp_unit_chk.sv
module vmp_unit_chk
  import vmp_pkg::*;
#(
  parameter int NSRC = 3
) (
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [NSRC*MODE_W-1:0] src_mode,
  input logic [NSRC-1:0]        src_used,
  input logic                   expl_en,
  input logic [MODE_W-1:0]      expl_mode,
  input logic                   mixed_ok,
  input logic                   len_ovr_en,
  input logic [LEN_W-1:0]       len_ovr,
  input logic                   kind_ovr_en,
  input logic                   kind_ovr_vec,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [MODE_W-1:0]      res_mode,
  input logic                   illegal,
  input logic                   dst_we
);
  always_comb begin
    if (expl_en) begin
      a_r3_explicit_wins: assert (res_mode == expl_mode && !illegal);
    end
    if (mixed_ok) begin
      a_r5_mixed_no_trap: assert (!illegal);
    end
    if (len_ovr_en && !expl_en) begin
      a_r6_len_override: assert (res_mode[LEN_W-1:0] == len_ovr);
    end
    if (kind_ovr_en && !expl_en) begin
      a_r7_kind_override: assert ((res_mode[MODE_W-1:LEN_W] != KIND_SCALAR) == kind_ovr_vec);
    end
    if (src_used == '0 && !expl_en && !kind_ovr_en && !len_ovr_en) begin
      a_r9_no_sources: assert (res_mode == '0 && !illegal);
    end
    if (illegal) begin
      a_r10_trap_blocks_write: assert (!dst_we);
    end
    if (dst_we) begin
      a_r11_write_on_transfer: assert (out_valid && in_ready);
    end
  end
endmodule

bind vmp_unit vmp_unit_chk #(.NSRC(NSRC)) chk_i (
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .src_mode     (src_mode),
  .src_used     (src_used),
  .expl_en      (expl_en),
  .expl_mode    (expl_mode),
  .mixed_ok     (mixed_ok),
  .len_ovr_en   (len_ovr_en),
  .len_ovr      (len_ovr),
  .kind_ovr_en  (kind_ovr_en),
  .kind_ovr_vec (kind_ovr_vec),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .res_mode     (res_mode),
  .illegal      (illegal),
  .dst_we       (dst_we)
);

// File: tb/vmp_unit_test.sv
`timescale 1ns/1ps
module vmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [11:0] src_mode;
  logic [2:0]  src_used;
  logic        expl_en, mixed_ok, len_ovr_en, kind_ovr_en, kind_ovr_vec;
  logic [3:0]  expl_mode, res_mode;
  logic [1:0]  len_ovr;
  logic        illegal, dst_we;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  vmp_unit #(.NSRC(3)) uut (
    .in_valid(in_valid), .in_ready(in_ready), .src_mode(src_mode), .src_used(src_used),
    .expl_en(expl_en), .expl_mode(expl_mode), .mixed_ok(mixed_ok),
    .len_ovr_en(len_ovr_en), .len_ovr(len_ovr), .kind_ovr_en(kind_ovr_en),
    .kind_ovr_vec(kind_ovr_vec), .out_valid(out_valid), .out_ready(out_ready),
    .res_mode(res_mode), .illegal(illegal), .dst_we(dst_we)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic defaults();
    in_valid = 1'b1; out_ready = 1'b1; src_used = 3'b111; src_mode = '0;
    expl_en = 1'b0; expl_mode = '0; mixed_ok = 1'b0;
    len_ovr_en = 1'b0; len_ovr = '0; kind_ovr_en = 1'b0; kind_ovr_vec = 1'b0;
  endtask

  // drive on the falling edge, sample a quarter period later
  task automatic apply(input logic [3:0] m2, input logic [3:0] m1, input logic [3:0] m0);
    @(negedge clk);
    src_mode = {m2, m1, m0};
    #5;
  endtask

  task automatic t_idle();
    defaults(); in_valid = 1'b0;
    apply(4'b0000, 4'b0101, 4'b0000);
    chk("R11 idle out_valid", {3'b0, out_valid}, 4'd0);
    chk("R11 idle dst_we", {3'b0, dst_we}, 4'd0);
    chk("R4 idle illegal", {3'b0, illegal}, 4'd0);
  endtask

  task automatic t_all_scalar();
    defaults();
    apply(4'b0011, 4'b0011, 4'b0011);
    chk("R7 all scalar len4", res_mode, 4'b0011);
    chk("R1 len code kept", {2'b0, res_mode[1:0]}, 4'd3);
    chk("R11 dst_we on transfer", {3'b0, dst_we}, 4'd1);
  endtask

  task automatic t_vector();
    defaults();
    apply(4'b0001, 4'b0101, 4'b0001);
    chk("R7 one vector source", res_mode, 4'b0101);
    chk("R2 unpredicated kind", {2'b0, res_mode[3:2]}, 4'd1);
  endtask

  task automatic t_pred();
    defaults();
    apply(4'b1110, 4'b1010, 4'b0010);
    chk("R8 first vector source kind", res_mode, 4'b1010);
  endtask

  task automatic t_mismatch();
    defaults();
    apply(4'b0000, 4'b0101, 4'b0000);
    chk("R4 mismatch illegal", {3'b0, illegal}, 4'd1);
    chk("R10 no write on trap", {3'b0, dst_we}, 4'd0);
  endtask

  task automatic t_mixed();
    defaults(); mixed_ok = 1'b1;
    apply(4'b0011, 4'b0101, 4'b0010);
    chk("R5 mixed no trap", {3'b0, illegal}, 4'd0);
    chk("R5 len from first used", res_mode, 4'b0110);
    src_used = 3'b110; #1;
    chk("R5 first used is src1", res_mode, 4'b0101);
  endtask

  task automatic t_len_ovr();
    defaults(); len_ovr_en = 1'b1; len_ovr = 2'b11;
    apply(4'b0100, 4'b0100, 4'b0100);
    chk("R6 len override", res_mode, 4'b0111);
  endtask

  task automatic t_kind_ovr();
    defaults(); kind_ovr_en = 1'b1; kind_ovr_vec = 1'b1;
    apply(4'b0001, 4'b0001, 4'b0001);
    chk("R8 forced vector defaults to 01", res_mode, 4'b0101);
    kind_ovr_vec = 1'b0; src_mode = {4'b1101, 4'b0101, 4'b0001}; #1;
    chk("R7 forced scalar", res_mode, 4'b0001);
  endtask

  task automatic t_explicit();
    defaults(); expl_en = 1'b1; expl_mode = 4'b1011;
    len_ovr_en = 1'b1; kind_ovr_en = 1'b1;
    apply(4'b0000, 4'b0111, 4'b0001);
    chk("R3 explicit mode", res_mode, 4'b1011);
    chk("R3 explicit no trap", {3'b0, illegal}, 4'd0);
  endtask

  task automatic t_unused();
    defaults(); src_used = 3'b011;
    apply(4'b1111, 4'b0010, 4'b0010);
    chk("R9 unused source ignored", res_mode, 4'b0010);
    chk("R9 unused no trap", {3'b0, illegal}, 4'd0);
    src_used = 3'b000; #1;
    chk("R9 no used sources", res_mode, 4'b0000);
  endtask

  task automatic t_backpressure();
    defaults(); out_ready = 1'b0;
    apply(4'b0000, 4'b0000, 4'b0000);
    chk("R11 in_ready follows", {3'b0, in_ready}, 4'd0);
    chk("R11 out_valid follows", {3'b0, out_valid}, 4'd1);
    chk("R11 no write stalled", {3'b0, dst_we}, 4'd0);
  endtask

  initial begin
    defaults(); in_valid = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle(); t_all_scalar(); t_vector(); t_pred(); t_mismatch(); t_mixed();
    t_len_ovr(); t_kind_ovr(); t_explicit(); t_unused(); t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule